// File: doc/BRIEF.md
# Flash Word-Program Sequencer

This block programs words into a parallel x16 NOR-style flash device from the host side. A requester presents a target address, a 16-bit data word, a last-word flag and a check-mode bit. The sequencer then runs a series of bus cycles, each with its own strobes. First it writes the program-setup command to the word address. Next it writes the data word to the same address. It then reads the status register until the ready bit is set, and ends by decoding the error flags. It returns one encoded result together with a single-cycle done pulse.

There are two check modes. In per-word mode the error flags are decoded after every word. In batch mode they are decoded only on the word flagged as last, so errors that build up in the device's sticky flags over a run are reported once. If an error is found or the poll times out, the sequencer writes the clear-status command and then writes the read-array command before it accepts another request. A successful last word ends with the read-array write alone.

Top module: `fwp_seq`

## Requirements
- R1: Out of reset, and whenever it is idle, the block holds req_ready high, holds done low, and keeps bus_ce_n, bus_oe_n and bus_we_n all high.
- R2: Each word begins with two writes to the request address. The first carries the setup command in the low byte (parameter SETUP_CMD, default 0x40; 0x10 is also valid). The second carries the data word.
- R3: After the data write, the status is read with one separate strobe per poll. Between polls bus_ce_n and bus_oe_n return high for at least one cycle. Polling stops at the first read with status bit 7 equal to 1, so a device busy for B reads is polled B+1 times.
- R4: Every bus access lasts STROBE_CYC+2 cycles: one issue cycle, then STROBE_CYC cycles with the strobe low, then one recovery cycle. done goes high exactly N*(STROBE_CYC+2) clock edges after the accepting edge, where N is the number of accesses for that word.
- R5: The result codes are 0 for pass, 1 for a locked block (status bit 1), 2 for low programming voltage (bit 3), 3 for program failure (bit 4) and 4 for timeout. When several bits are set, the locked block is reported ahead of voltage, and voltage ahead of program failure.
- R6: With check_each = 1 the error bits are decoded on every word. With check_each = 0 a word that is not last reports pass whatever the status holds, and the last word reports the flags that have built up since the last clear.
- R7: A word that is last or ends in an error finishes with a write of 0xFF. A word that passes and is not last adds no write after the data write.
- R8: When a word ends in any error, a write of CLEAR_CMD (default 0x50) comes before the 0xFF write.
- R9: If POLL_MAX status reads in a row show bit 7 equal to 0, the word ends with result 4 after exactly POLL_MAX reads. A device that becomes ready on read POLL_MAX still passes.
- R10: done is high for exactly one cycle. bus_we_n and bus_oe_n are never low together. bus_dq_oe is never high while bus_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_addr | input | AW | Word address |
| req_data | input | DW | Word to program |
| req_last | input | 1 | Final word of a run |
| check_each | input | 1 | 1: decode status on every word; 0: only on last |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Encoded outcome, valid with done |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | Flash address |
| bus_dq_out | output | DW | Write data toward the flash |
| bus_dq_oe | output | 1 | Host drives the data bus |
| bus_sr_in | input | 8 | Low byte of the data bus during reads |

## Verification
The main timing fact is the done pulse. It comes N*(STROBE_CYC+2) edges after the edge that accepts the request. N is computed from the requirements: two writes, then the poll count (B+1, or POLL_MAX on timeout), then zero, one or two tail writes. The bench counts rising edges from acceptance and samples done on each falling edge, so it catches both an early pulse and a late one. The flash model responds to the strobes as they happen. Its write and read logs are compared only after done, when the word's bus activity has finished.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam int SR_READY_BIT = 7;

    typedef enum logic [2:0] {
        RES_PASS      = 3'd0,
        RES_LOCKED    = 3'd1,
        RES_VPP_LOW   = 3'd2,
        RES_PROG_FAIL = 3'd3,
        RES_TIMEOUT   = 3'd4
    } fwp_result_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_SETUP, SQ_DATA, SQ_POLL, SQ_CLEAR, SQ_RESET, SQ_DONE
    } fwp_state_e;

    typedef enum logic [1:0] {
        BC_IDLE, BC_ACT, BC_REC
    } fwp_phase_e;

endpackage

// File: rtl/fwp_bus_cycle.sv
module fwp_bus_cycle
    import fwp_pkg::*;
#(
    parameter int AW         = 21,
    parameter int DW         = 16,
    parameter int STROBE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [7:0]    bus_sr_in,
    output logic          ack,
    output logic [7:0]    rdata,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    localparam int CW = $clog2(STROBE_CYC) + 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYC - 1);

    typedef struct packed {
        fwp_phase_e    phase;
        logic          rd;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [7:0]    rdata;
    } bc_t;

    bc_t q, d;

    always_comb begin
        d = q;
        case (q.phase)
            BC_IDLE: begin
                if (start) begin
                    d.phase = BC_ACT;
                    d.rd    = rd;
                    d.cnt   = '0;
                    d.addr  = addr_in;
                    d.wdata = wdata_in;
                end
            end
            BC_ACT: begin
                if (q.cnt == CNT_LAST) begin
                    d.phase = BC_REC;
                    if (q.rd) d.rdata = bus_sr_in;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.phase = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: BC_IDLE, rd: 1'b0, cnt: '0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign ack      = (q.phase == BC_REC);
    assign rdata    = q.rdata;
    assign ce_n     = (q.phase != BC_ACT);
    assign oe_n     = !((q.phase == BC_ACT) && q.rd);
    assign we_n     = !((q.phase == BC_ACT) && !q.rd);
    assign dq_oe    = (q.phase == BC_ACT) && !q.rd;
    assign bus_addr = q.addr;
    assign dq_out   = q.wdata;

endmodule

// File: rtl/fwp_poll_timer.sv
module fwp_poll_timer #(
    parameter int POLL_MAX = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CW = $clog2(POLL_MAX) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(POLL_MAX - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == LIMIT);

endmodule

// File: rtl/fwp_status_decode.sv
module fwp_status_decode
    import fwp_pkg::*;
(
    input  logic [7:0]  status,
    output fwp_result_e code
);
    always_comb begin
        casez (status)
            8'b????_??1?: code = RES_LOCKED;
            8'b????_1???: code = RES_VPP_LOW;
            8'b???1_????: code = RES_PROG_FAIL;
            default:      code = RES_PASS;
        endcase
    end
endmodule

// File: rtl/fwp_seq.sv
module fwp_seq
    import fwp_pkg::*;
#(
    parameter int          AW         = 21,
    parameter int          DW         = 16,
    parameter int          STROBE_CYC = 2,
    parameter int          POLL_MAX   = 1024,
    parameter logic [7:0]  SETUP_CMD  = 8'h40,
    parameter logic [7:0]  CLEAR_CMD  = 8'h50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_last,
    input  logic          check_each,
    output logic          done,
    output logic [2:0]    result,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dq_out,
    output logic          bus_dq_oe,
    input  logic [7:0]    bus_sr_in
);
    localparam logic [7:0]    ARRAY_CMD = 8'hFF;
    localparam logic [DW-9:0] PAD       = '0;

    typedef struct packed {
        fwp_state_e    state;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          last;
        logic          chk;
        logic          issued;
        fwp_result_e   code;
    } seq_t;

    seq_t q, d;

    logic          op_start, op_rd, op_ack, poll_clr, poll_inc, poll_hit;
    logic [DW-1:0] op_wdata;
    logic [7:0]    op_rdata;
    fwp_result_e   dec_code;

    fwp_bus_cycle #(.AW(AW), .DW(DW), .STROBE_CYC(STROBE_CYC)) u_cyc (
        .clk(clk), .rst_n(rst_n), .start(op_start), .rd(op_rd),
        .addr_in(q.addr), .wdata_in(op_wdata), .bus_sr_in(bus_sr_in),
        .ack(op_ack), .rdata(op_rdata), .ce_n(bus_ce_n), .oe_n(bus_oe_n),
        .we_n(bus_we_n), .bus_addr(bus_addr), .dq_out(bus_dq_out), .dq_oe(bus_dq_oe)
    );

    fwp_poll_timer #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .hit(poll_hit)
    );

    fwp_status_decode u_dec (.status(op_rdata), .code(dec_code));

    always_comb begin
        case (q.state)
            SQ_SETUP: op_wdata = {PAD, SETUP_CMD};
            SQ_DATA:  op_wdata = q.data;
            SQ_CLEAR: op_wdata = {PAD, CLEAR_CMD};
            default:  op_wdata = {PAD, ARRAY_CMD};
        endcase
        op_rd    = (q.state == SQ_POLL);
        op_start = !q.issued && (q.state != SQ_IDLE) && (q.state != SQ_DONE);
    end

    always_comb begin
        d        = q;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        if (op_start) d.issued = 1'b1;
        if (op_ack)   d.issued = 1'b0;
        case (q.state)
            SQ_IDLE: begin
                if (req_valid) begin
                    d.state = SQ_SETUP;
                    d.addr  = req_addr;
                    d.data  = req_data;
                    d.last  = req_last;
                    d.chk   = check_each;
                    d.code  = RES_PASS;
                end
            end
            SQ_SETUP: if (op_ack) d.state = SQ_DATA;
            SQ_DATA: begin
                if (op_ack) begin
                    d.state  = SQ_POLL;
                    poll_clr = 1'b1;
                end
            end
            SQ_POLL: begin
                if (op_ack) begin
                    if (op_rdata[SR_READY_BIT]) begin
                        if ((q.chk || q.last) && (dec_code != RES_PASS)) begin
                            d.code  = dec_code;
                            d.state = SQ_CLEAR;
                        end else if (q.last) begin
                            d.state = SQ_RESET;
                        end else begin
                            d.state = SQ_DONE;
                        end
                    end else if (poll_hit) begin
                        d.code  = RES_TIMEOUT;
                        d.state = SQ_CLEAR;
                    end else begin
                        poll_inc = 1'b1;
                    end
                end
            end
            SQ_CLEAR: if (op_ack) d.state = SQ_RESET;
            SQ_RESET: if (op_ack) d.state = SQ_DONE;
            default:  d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SQ_IDLE, addr: '0, data: '0, last: 1'b0, chk: 1'b0,
                   issued: 1'b0, code: RES_PASS};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == SQ_IDLE);
    assign done      = (q.state == SQ_DONE);
    assign result    = q.code;

endmodule

// File: rtl/fwp_seq_chk.sv
module fwp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic [2:0] result,
    input logic       bus_ce_n,
    input logic       bus_oe_n,
    input logic       bus_we_n,
    input logic       bus_dq_oe
);
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_ce_n && bus_oe_n && bus_we_n)); // R1
    AST_FRESH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ce_n) |=> bus_ce_n); // R3
    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd4)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_oe_n)); // R10
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_dq_oe); // R10
    AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n); // R10
endmodule

bind fwp_seq fwp_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .result(result),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_dq_oe(bus_dq_oe)
);

// File: tb/fwp_seq_bench.sv
module fwp_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int S  = 2;
    localparam int PM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_last = 1'b0;
    logic          check_each = 1'b0;
    logic          done;
    logic [2:0]    result;
    logic          bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dq_out;
    logic [7:0]    bus_sr_in;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwp_seq #(.AW(AW), .DW(DW), .STROBE_CYC(S), .POLL_MAX(PM)) u_fwp_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
        .check_each(check_each), .done(done), .result(result),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
        .bus_sr_in(bus_sr_in)
    );

    // Flash model: sticky[0]=locked(bit1), sticky[1]=voltage(bit3), sticky[2]=fail(bit4)
    logic [7:0]    sr_lat = 8'h00;
    logic [2:0]    sticky = 3'b000;
    logic          want_data = 1'b0;
    logic          we_p = 1'b1, oe_p = 1'b1;
    int            busy_left = 0;
    int            m_busy = 0;
    logic [2:0]    m_inj = 3'b000;
    int            wcnt = 0, rcnt = 0;
    logic [AW-1:0] wl_addr [0:7];
    logic [DW-1:0] wl_data [0:7];

    assign bus_sr_in = sr_lat;

    always @(posedge clk) begin
        if (rst_n) begin
            if (!we_p && bus_we_n) begin
                if (wcnt < 8) begin
                    wl_addr[wcnt] = bus_addr;
                    wl_data[wcnt] = bus_dq_out;
                end
                wcnt = wcnt + 1;
                if (want_data) begin
                    want_data = 1'b0;
                    busy_left = m_busy;
                    sticky    = sticky | m_inj;
                end else if (bus_dq_out[7:0] == 8'h40 || bus_dq_out[7:0] == 8'h10) begin
                    want_data = 1'b1;
                end else if (bus_dq_out[7:0] == 8'h50) begin
                    sticky = 3'b000;
                end
            end
            if (oe_p && !bus_oe_n)
                sr_lat <= {(busy_left == 0), 2'b00, sticky[2], sticky[1], 1'b0, sticky[0], 1'b0};
            if (!oe_p && bus_oe_n) begin
                rcnt = rcnt + 1;
                if (busy_left > 0) busy_left = busy_left - 1;
            end
        end
        we_p = bus_we_n;
        oe_p = bus_oe_n;
    end

    // Port-level protocol monitor
    int   viol = 0;
    logic done_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_we_n && !bus_oe_n) viol = viol + 1;
            if (!bus_oe_n && bus_dq_oe) viol = viol + 1;
            if (done && done_p)         viol = viol + 1;
        end
        done_p = done;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int prio(input logic [2:0] st);
        if (st[0]) return 1;
        if (st[1]) return 2;
        if (st[2]) return 3;
        return 0;
    endfunction

    logic [2:0] sticky_exp = 3'b000;

    task automatic do_word(input logic [AW-1:0] a, input logic [DW-1:0] dat,
                           input bit last, input bit chk, input int busy,
                           input logic [2:0] inj);
        int  exp_code, tail, reads, ops, cyc;
        bit  tmo, err, seq_ok, tail_ok;
        sticky_exp = sticky_exp | inj;
        tmo = (busy >= PM);
        if (tmo)              exp_code = 4;
        else if (chk || last) exp_code = prio(sticky_exp);
        else                  exp_code = 0;
        err = (exp_code != 0);
        if (err) sticky_exp = 3'b000;
        tail  = err ? 2 : (last ? 1 : 0);
        reads = tmo ? PM : busy + 1;
        ops   = 2 + reads + tail;

        @(negedge clk);
        check(req_ready == 1'b1, "R1", int'(req_ready), 1);
        wcnt = 0; rcnt = 0; m_busy = busy; m_inj = inj;
        req_addr = a; req_data = dat; req_last = last; check_each = chk; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        check(cyc == ops * (S + 2), "R4 latency", cyc, ops * (S + 2));
        if (tmo) check(int'(result) == exp_code, "R9 timeout code", int'(result), exp_code);
        else if (!chk && !last) check(int'(result) == exp_code, "R6 batch pass", int'(result), exp_code);
        else check(int'(result) == exp_code, "R5 code", int'(result), exp_code);
        check(rcnt == reads, tmo ? "R9 poll count" : "R3 poll count", rcnt, reads);
        seq_ok = (wcnt >= 2) && wl_addr[0] == a && wl_data[0] == 16'h0040
                 && wl_addr[1] == a && wl_data[1] == dat;
        check(seq_ok, "R2 setup/data", wcnt, 2 + tail);
        if (err)       tail_ok = (wcnt == 4) && wl_data[2] == 16'h0050 && wl_data[3] == 16'h00FF;
        else if (last) tail_ok = (wcnt == 3) && wl_data[2] == 16'h00FF;
        else           tail_ok = (wcnt == 2);
        check(tail_ok, err ? "R8 clear then array" : "R7 tail writes", wcnt, 2 + tail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && bus_ce_n && bus_oe_n && bus_we_n && !done, "R1 reset state",
              {req_ready, bus_ce_n, bus_oe_n, bus_we_n, done}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_ready && !done, "R1 idle after reset", int'(req_ready), 1);

        // directed corner cases
        do_word(8'h11, 16'hA5A5, 1, 1, 0, 3'b000);      // immediate ready, pass
        do_word(8'h12, 16'h1234, 1, 1, 2, 3'b001);      // locked
        do_word(8'h13, 16'h5678, 0, 1, 1, 3'b010);      // voltage, not last
        do_word(8'h14, 16'h9ABC, 1, 1, 3, 3'b100);      // program fail
        do_word(8'h15, 16'hDEF0, 1, 1, 1, 3'b111);      // R5 priority -> locked
        do_word(8'h16, 16'h0F0F, 1, 1, 0, 3'b110);      // R5 priority -> voltage
        do_word(8'h17, 16'h3333, 0, 0, 2, 3'b100);      // R6 batch: error hidden
        do_word(8'h18, 16'h4444, 0, 0, 1, 3'b000);      // R6 batch: still hidden
        do_word(8'h19, 16'h5555, 1, 0, 0, 3'b000);      // R6 batch: reported at last
        do_word(8'h1A, 16'h6666, 1, 1, PM, 3'b000);     // R9 timeout
        do_word(8'h1B, 16'h7777, 1, 1, PM - 1, 3'b000); // R9 boundary pass
        do_word(8'h1C, 16'h8888, 0, 1, 4, 3'b000);      // R7 no tail on pass
        do_word(8'h1D, 16'h9999, 1, 0, 0, 3'b000);      // close the run

        for (int i = 0; i < 40; i++) begin
            logic [2:0] inj;
            inj = (($urandom % 5) == 0) ? 3'($urandom % 8) : 3'b000;
            do_word(AW'($urandom), DW'($urandom), (($urandom % 4) == 0),
                    1'($urandom % 2), int'($urandom % 11), inj);
        end

        check(viol == 0, "R10 strobe/drive/pulse", viol, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule